// File: doc/BRIEF.md
# Byte-Paced I2C Bus Master

This block is an I2C bus master that software steers one byte at a time. Four registers face software: control, status, a data buffer and an own-address register. Software loads a byte into the data buffer and then writes the control register with the transfer-byte bit set. Companion bits in the same write choose whether a START (or a repeated START when the bus is already held) comes before the byte, whether a STOP follows it, and whether a received byte is answered with NACK.

The first byte after a START is always sent. It is the target address shifted left by one, with bit 0 set for a read and cleared for a write. That bit fixes the direction of every data byte until the next START. At the end of each byte a transmit-empty or receive-full flag is raised. Received bytes can then be read from the data buffer. Every flag clears when a 1 is written to its bit, and an interrupt line is high while any flag with its enable set is pending.

The bus clock comes from a quarter-bit tick divider. The block drives both lines open-drain: an output enable of 1 pulls the wire low. SDA is read back through a two-stage synchroniser, both to catch a target's NACK and to detect lost arbitration.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, control (address 0) and status (address 1) read 0, both line enables are 0 and irq is 0; the own-address register (address 3) reads back its 7-bit written value.
- R2: Writing control with transfer-byte (bit 6), START (bit 3) and unit-enable (bit 0) set generates a START and sends the data buffer (address 2) MSB first. When the target ACKs, transmit-empty (status bit 7) is set and bit 6 of control reads 0.
- R3: A transfer-byte command with START clear and STOP (bit 4) set moves one byte and then a STOP. Busy (status bit 0) then falls, and both line enables read 0.
- R4: Without STOP, busy stays 1 and SCL is held low after the byte. A later START command produces a repeated START.
- R5: In read direction, bytes are shifted in MSB first and are readable from the data buffer once receive-full (status bit 6) is set. Each byte is ACKed unless NACK (control bit 5) is set.
- R6: A NACK received after a sent byte sets bus-error (status bit 5), releases both lines and clears busy.
- R7: If SDA is released for a 1 bit but sampled low, arbitration-lost (status bit 4) is set and both lines are released.
- R8: Writing 1 to a flag's status bit clears it. Writing 0 leaves it unchanged.
- R9: irq is the OR of each flag ANDed with its enable. The enables sit at control bits 8 (transmit-empty), 9 (receive-full), 10 (bus-error) and 11 (arbitration-lost).
- R10: While unit-reset (control bit 7) is set, the engine is aborted and both lines are released. A transfer-byte write with unit-enable clear is ignored, and bit 6 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_addr | input | 2 | register select: 0 control, 1 status, 2 data, 3 own address |
| reg_wr | input | 1 | write strobe for the selected register |
| reg_wdata | input | 12 | write data |
| reg_rdata | output | 12 | read data of the selected register (combinational) |
| sda_i | input | 1 | sampled SDA wire level |
| scl_oe | output | 1 | 1 pulls SCL low (only while SCL drive enable, control bit 1, is set) |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | interrupt request |

## Verification
Each bus step lasts one quarter-bit tick of QDIV clocks. A sent or received byte takes 36 ticks, a START adds 2 ticks, a repeated START adds 4, and a STOP adds 3 after the byte's flag. The completion flag and the clearing of transfer-byte both happen at the clock edge that ends the ACK bit. Busy falls at the edge that ends the STOP. Because these delays depend on QDIV, the bench does not wait a fixed number of cycles: it polls transfer-byte or busy once per clock at the falling edge, and only then samples status, data and line enables. irq and the line releases that follow a unit reset are combinational or one register away, so they are checked at the falling edge right after the write.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  // control register bit positions
  localparam int CB_UEN   = 0;
  localparam int CB_SCLEN = 1;
  localparam int CB_GCDIS = 2;
  localparam int CB_START = 3;
  localparam int CB_STOP  = 4;
  localparam int CB_NACK  = 5;
  localparam int CB_XFER  = 6;
  localparam int CB_URST  = 7;
  localparam int CB_IE0   = 8;
  localparam int CTRL_BITS = 12;

  // flag indices; flag i lives at status bit SB_FTOP-i, its enable at CB_IE0+i
  localparam int NFLAG   = 4;
  localparam int FL_TX   = 0;
  localparam int FL_RX   = 1;
  localparam int FL_BERR = 2;
  localparam int FL_ARB  = 3;
  localparam int SB_BUSY = 0;
  localparam int SB_FTOP = 7;
  localparam int STAT_BITS = 8;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_DATA = 2'd2;
  localparam logic [1:0] RA_OWN  = 2'd3;

  typedef enum logic [3:0] {
    E_IDLE, E_RS1, E_RS2, E_ST1, E_ST2, E_BIT, E_SP1, E_SP2, E_SP3
  } eng_state_e;

  typedef struct packed {
    logic       start;
    logic       stop;
    logic       nack;
    logic [7:0] dat;
  } cmd_t;
endpackage

// File: rtl/i2c_bm_tick.sv
module i2c_bm_tick #(
  parameter int QDIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    tick  = run && (cnt_q == LAST);
    cnt_n = cnt_q;
    if (!run || tick) cnt_n = '0;
    else              cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/i2c_bm_engine.sv
module i2c_bm_engine
  import i2c_bm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             go,
  input  cmd_t             cmd,
  input  logic             sda_in,
  input  logic             tick,
  output logic             run,
  output logic             busy,
  output logic             scl_drv,
  output logic             sda_drv,
  output logic             done,
  output logic [NFLAG-1:0] ev,
  output logic [DW-1:0]    rx_byte
);
  localparam int BCW = $clog2(DW + 2);
  localparam logic [BCW-1:0] ACK_BIT = BCW'(DW);

  eng_state_e st_q, st_n;
  logic [1:0]     qp_q, qp_n;
  logic [BCW-1:0] bit_q, bit_n;
  logic [DW-1:0]  sh_q, sh_n;
  logic owned_q, owned_n, rdm_q, rdm_n, rdn_q, rdn_n;
  logic stop_q, stop_n, nack_q, nack_n, scl_q, scl_n, sda_q, sda_n;

  always_comb begin
    st_n = st_q; qp_n = qp_q; bit_n = bit_q; sh_n = sh_q;
    owned_n = owned_q; rdm_n = rdm_q; rdn_n = rdn_q;
    stop_n = stop_q; nack_n = nack_q; scl_n = scl_q; sda_n = sda_q;
    done = 1'b0;
    ev   = '0;
    unique case (st_q)
      E_IDLE: if (go) begin
        stop_n = cmd.stop;
        nack_n = cmd.nack;
        sh_n   = cmd.dat[DW-1:0];
        bit_n  = '0;
        qp_n   = 2'd0;
        if (cmd.start) begin
          rdn_n = 1'b0;
          rdm_n = cmd.dat[0];
          st_n  = owned_q ? E_RS1 : E_ST1;
        end else begin
          rdn_n = rdm_q;
          st_n  = E_BIT;
        end
      end
      E_RS1: if (tick) begin sda_n = 1'b0; st_n = E_RS2; end
      E_RS2: if (tick) begin scl_n = 1'b0; st_n = E_ST1; end
      E_ST1: if (tick) begin sda_n = 1'b1; st_n = E_ST2; end
      E_ST2: if (tick) begin scl_n = 1'b1; st_n = E_BIT; end
      E_BIT: if (tick) begin
        unique case (qp_q)
          2'd0: begin
            if (bit_q < ACK_BIT) sda_n = rdn_q ? 1'b0 : ~sh_q[DW-1];
            else                 sda_n = rdn_q ? ~nack_q : 1'b0;
            qp_n = 2'd1;
          end
          2'd1: begin
            scl_n = 1'b0;
            qp_n  = 2'd2;
          end
          2'd2: begin
            qp_n = 2'd3;
            if (bit_q < ACK_BIT) begin
              if (rdn_q) sh_n = {sh_q[DW-2:0], sda_in};
              else if (!sda_q && !sda_in) begin
                ev[FL_ARB] = 1'b1;
                done = 1'b1; scl_n = 1'b0; sda_n = 1'b0;
                owned_n = 1'b0; st_n = E_IDLE;
              end
            end else if (!rdn_q && sda_in) begin
              ev[FL_BERR] = 1'b1;
              done = 1'b1; scl_n = 1'b0; sda_n = 1'b0;
              owned_n = 1'b0; st_n = E_IDLE;
            end
          end
          default: begin
            scl_n = 1'b1;
            if (bit_q == ACK_BIT) begin
              done    = 1'b1;
              ev[rdn_q ? FL_RX : FL_TX] = 1'b1;
              owned_n = 1'b1;
              st_n    = stop_q ? E_SP1 : E_IDLE;
            end else begin
              bit_n = bit_q + 1'b1;
              if (!rdn_q) sh_n = {sh_q[DW-2:0], 1'b0};
              qp_n  = 2'd0;
            end
          end
        endcase
      end
      E_SP1: if (tick) begin sda_n = 1'b1; st_n = E_SP2; end
      E_SP2: if (tick) begin scl_n = 1'b0; st_n = E_SP3; end
      E_SP3: if (tick) begin sda_n = 1'b0; owned_n = 1'b0; st_n = E_IDLE; end
      default: st_n = E_IDLE;
    endcase
    if (abort) begin
      st_n = E_IDLE; owned_n = 1'b0; scl_n = 1'b0; sda_n = 1'b0;
      done = 1'b0; ev = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= E_IDLE; qp_q <= '0; bit_q <= '0; sh_q <= '0;
      owned_q <= 1'b0; rdm_q <= 1'b0; rdn_q <= 1'b0;
      stop_q <= 1'b0; nack_q <= 1'b0; scl_q <= 1'b0; sda_q <= 1'b0;
    end else begin
      st_q <= st_n; qp_q <= qp_n; bit_q <= bit_n; sh_q <= sh_n;
      owned_q <= owned_n; rdm_q <= rdm_n; rdn_q <= rdn_n;
      stop_q <= stop_n; nack_q <= nack_n; scl_q <= scl_n; sda_q <= sda_n;
    end
  end

  assign run     = (st_q != E_IDLE);
  assign busy    = run | owned_q;
  assign scl_drv = scl_q;
  assign sda_drv = sda_q;
  assign rx_byte = sh_q;
endmodule

// File: rtl/i2c_bm_regs.sv
module i2c_bm_regs
  import i2c_bm_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 7,
  parameter int BW = CTRL_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic [BW-1:0]        reg_wdata,
  input  logic                 eng_done,
  input  logic [NFLAG-1:0]     eng_ev,
  input  logic                 eng_busy,
  input  logic [DW-1:0]        rx_byte,
  output logic [CTRL_BITS-1:0] ctrl_q,
  output logic [NFLAG-1:0]     flags_q,
  output logic [DW-1:0]        data_q,
  output logic                 irq,
  output logic [BW-1:0]        reg_rdata
);
  logic [CTRL_BITS-1:0] ctrl_n;
  logic [NFLAG-1:0]     flags_n;
  logic [DW-1:0]        data_n;
  logic [AW-1:0]        own_q, own_n;
  logic [STAT_BITS-1:0] stat_w;
  logic wr_ctrl, wr_stat, wr_data, wr_own;

  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_stat = reg_wr && (reg_addr == RA_STAT);
  assign wr_data = reg_wr && (reg_addr == RA_DATA);
  assign wr_own  = reg_wr && (reg_addr == RA_OWN);

  always_comb begin
    ctrl_n = ctrl_q;
    if (eng_done) ctrl_n[CB_XFER] = 1'b0;
    if (wr_ctrl) begin
      ctrl_n = reg_wdata[CTRL_BITS-1:0];
      ctrl_n[CB_XFER] = reg_wdata[CB_XFER] & reg_wdata[CB_UEN] & ~reg_wdata[CB_URST];
    end
  end

  // set by the engine wins over a simultaneous write-one clear
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_comb begin
      if (eng_ev[i])                        flags_n[i] = 1'b1;
      else if (wr_stat && reg_wdata[SB_FTOP-i]) flags_n[i] = 1'b0;
      else                                  flags_n[i] = flags_q[i];
    end
  end

  always_comb begin
    data_n = data_q;
    if (eng_ev[FL_RX]) data_n = rx_byte;
    if (wr_data)       data_n = reg_wdata[DW-1:0];
    own_n = wr_own ? reg_wdata[AW-1:0] : own_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; flags_q <= '0; data_q <= '0; own_q <= '0;
    end else begin
      ctrl_q <= ctrl_n; flags_q <= flags_n; data_q <= data_n; own_q <= own_n;
    end
  end

  always_comb begin
    stat_w = '0;
    stat_w[SB_BUSY] = eng_busy;
    for (int i = 0; i < NFLAG; i++) stat_w[SB_FTOP-i] = flags_q[i];
  end

  assign irq = |(flags_q & ctrl_q[CB_IE0 +: NFLAG]);

  always_comb begin
    unique case (reg_addr)
      RA_CTRL: reg_rdata = BW'(ctrl_q);
      RA_STAT: reg_rdata = BW'(stat_w);
      RA_DATA: reg_rdata = BW'(data_q);
      default: reg_rdata = BW'(own_q);
    endcase
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int QDIV = 250,
  parameter int DW   = 8,
  parameter int BW   = CTRL_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [BW-1:0] reg_wdata,
  output logic [BW-1:0] reg_rdata,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          irq
);
  logic [CTRL_BITS-1:0] ctrl_w;
  logic [NFLAG-1:0]     flags_w, ev_w;
  logic [DW-1:0]        data_w, rx_w;
  logic done_w, busy_w, run_w, tick_w, scl_drv_w, sda_drv_w;
  logic go_w, xfer_w, urst_w;
  logic [1:0] sda_sync_q;
  cmd_t cmd_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_sync_q <= 2'b11;
    else        sda_sync_q <= {sda_sync_q[0], sda_i};
  end

  assign xfer_w = ctrl_w[CB_XFER];
  assign urst_w = ctrl_w[CB_URST];
  assign go_w   = xfer_w & ctrl_w[CB_UEN] & ~urst_w;

  always_comb begin
    cmd_w       = '0;
    cmd_w.start = ctrl_w[CB_START];
    cmd_w.stop  = ctrl_w[CB_STOP];
    cmd_w.nack  = ctrl_w[CB_NACK];
    cmd_w.dat   = 8'(data_w);
  end

  i2c_bm_regs #(.DW(DW), .AW(7), .BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .eng_done(done_w), .eng_ev(ev_w),
    .eng_busy(busy_w), .rx_byte(rx_w), .ctrl_q(ctrl_w), .flags_q(flags_w),
    .data_q(data_w), .irq(irq), .reg_rdata(reg_rdata)
  );

  i2c_bm_tick #(.QDIV(QDIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run_w), .tick(tick_w)
  );

  i2c_bm_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .abort(urst_w), .go(go_w), .cmd(cmd_w),
    .sda_in(sda_sync_q[1]), .tick(tick_w), .run(run_w), .busy(busy_w),
    .scl_drv(scl_drv_w), .sda_drv(sda_drv_w), .done(done_w), .ev(ev_w),
    .rx_byte(rx_w)
  );

  assign scl_oe = scl_drv_w & ctrl_w[CB_SCLEN];
  assign sda_oe = sda_drv_w;
endmodule

// File: rtl/i2c_bm_checker.sv
module i2c_bm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       irq,
  input logic       busy,
  input logic [3:0] flags,
  input logic       xfer,
  input logic       urst
);
  // flag order: 0 tx-empty, 1 rx-full, 2 bus-error, 3 arbitration-lost
  assert_done_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(xfer) && !urst) |-> (flags != 4'b0000));

  assert_free_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  assert_berr_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> (!scl_oe && !sda_oe && !busy));

  assert_arb_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[3]) |-> (!scl_oe && !sda_oe && !busy));

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 4'b0000) |-> !irq);

  assert_reset_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    urst |=> (!scl_oe && !sda_oe));
endmodule

bind i2c_byte_master i2c_bm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
  .busy(busy_w), .flags(flags_w), .xfer(xfer_w), .urst(urst_w)
);

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
  localparam int QD = 4;
  localparam logic [6:0] SL = 7'h5A;
  localparam logic [11:0] BASE = 12'h003, STA = 12'h008, STO = 12'h010,
                          NAK = 12'h020, XF = 12'h040, URST = 12'h080;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, reg_wr = 1'b0, jam = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [11:0] reg_wdata = '0;
  logic [11:0] reg_rdata;
  logic scl_oe, sda_oe, irq, sda_i;
  logic s_oe = 1'b0;
  logic scl_bus, sda_bus;
  assign scl_bus = ~scl_oe;
  assign sda_bus = ~(sda_oe | s_oe | jam);
  assign sda_i   = sda_bus;

  i2c_byte_master #(.QDIV(QD)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  int n_chk = 0, n_err = 0;
  logic [7:0] exp_wr[$];
  logic [7:0] exp_rd[$];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rdv(input int n);
    return 8'h3C ^ 8'(n * 8'h25);
  endfunction

  // ---------------- target model and write monitor ----------------
  logic p_scl = 1'b1, p_sda = 1'b1, s_act = 1'b0, s_aph = 1'b0, s_rd = 1'b0;
  logic s_tx = 1'b0, s_match = 1'b0, s_mack = 1'b0;
  logic [7:0] s_sh = '0, s_out = '0;
  int s_bit = 0, s_rdn = 0, s_starts = 0;

  always @(posedge clk) begin
    p_scl <= scl_bus;
    p_sda <= sda_bus;
    if (p_scl && scl_bus && p_sda && !sda_bus) begin
      s_act <= 1'b1; s_bit <= 0; s_aph <= 1'b1; s_oe <= 1'b0; s_tx <= 1'b0;
      s_starts <= s_starts + 1;
    end else if (p_scl && scl_bus && !p_sda && sda_bus) begin
      s_act <= 1'b0; s_oe <= 1'b0; s_tx <= 1'b0;
    end else if (s_act && !p_scl && scl_bus) begin
      s_bit <= s_bit + 1;
      if (s_bit < 8 && !s_tx) s_sh <= {s_sh[6:0], sda_bus};
      if (s_bit == 8 && s_tx) s_mack <= !sda_bus;
    end else if (s_act && p_scl && !scl_bus) begin
      if (s_bit == 8) begin
        if (!s_tx) begin
          if (s_aph) begin
            s_match <= (s_sh[7:1] == SL);
            s_rd    <= s_sh[0];
            s_oe    <= (s_sh[7:1] == SL);
          end else if (s_match) begin
            s_oe <= 1'b1;
            if (exp_wr.size() == 0) chk("R3", "unexpected written byte", 32'(s_sh), 32'hFFFF);
            else chk("R2", "byte seen by target", 32'(s_sh), 32'(exp_wr.pop_front()));
          end
        end else s_oe <= 1'b0;
      end else if (s_bit == 9) begin
        s_bit <= 0;
        s_aph <= 1'b0;
        if (s_match && s_rd && (s_aph || (s_tx && s_mack))) begin
          s_tx  <= 1'b1;
          s_oe  <= !rdv(s_rdn)[7];
          s_out <= rdv(s_rdn) << 1;
          s_rdn <= s_rdn + 1;
        end else begin
          s_tx <= 1'b0; s_oe <= 1'b0;
        end
      end else if (s_tx) begin
        s_oe  <= !s_out[7];
        s_out <= s_out << 1;
      end
    end
  end

  // ---------------- register access ----------------
  task automatic wr(input logic [1:0] a, input logic [11:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [11:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_xfer(input string req);
    logic [11:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(2'd0, v);
      if (!v[6]) return;
    end
    chk(req, "transfer-byte never cleared", 1, 0);
  endtask

  task automatic wait_idle(input string req);
    logic [11:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(2'd1, v);
      if (!v[0]) return;
    end
    chk(req, "busy never fell", 1, 0);
  endtask

  task automatic send(input logic [7:0] b, input bit stop);
    logic [11:0] v;
    exp_wr.push_back(b);
    wr(2'd2, 12'(b));
    wr(2'd0, BASE | XF | (stop ? STO : 12'h0));
    wait_xfer("R3");
    rd(2'd1, v);
    chk("R3", "tx-empty after data byte", 32'(v[7:4]), 32'h8);
    wr(2'd1, 12'h080);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [11:0] v;
    int st0, rn;
    rn = 0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk("R1", "control after reset", 32'(v), 0);
    rd(2'd1, v); chk("R1", "status after reset", 32'(v), 0);
    chk("R1", "line enables after reset", {scl_oe, sda_oe}, 0);
    chk("R1", "irq after reset", 32'(irq), 0);
    wr(2'd3, 12'h011); rd(2'd3, v); chk("R1", "own address", 32'(v), 32'h011);

    // R2 address byte, write direction
    wr(2'd0, BASE);
    wr(2'd2, 12'({SL, 1'b0}));
    wr(2'd0, BASE | STA | XF);
    wait_xfer("R2");
    rd(2'd1, v);
    chk("R2", "flags after address", 32'(v[7:4]), 32'h8);
    chk("R4", "busy held between bytes", 32'(v[0]), 1);
    chk("R4", "SCL held low between bytes", 32'(scl_oe), 1);
    wr(2'd1, 12'h080); rd(2'd1, v);
    chk("R8", "tx-empty cleared by write-one", 32'(v[7:4]), 0);
    send(8'h11, 1'b0);
    send(8'h7E, 1'b0);
    send(8'hC5, 1'b1);
    wait_idle("R3");
    chk("R3", "lines released after STOP", {scl_oe, sda_oe}, 0);
    chk("R3", "all written bytes reached target", exp_wr.size(), 0);

    // R4/R5 write then repeated START read
    st0 = s_starts;
    wr(2'd2, 12'({SL, 1'b0})); wr(2'd0, BASE | STA | XF); wait_xfer("R4");
    wr(2'd1, 12'h080);
    send(8'h42, 1'b0);
    rd(2'd1, v); chk("R4", "busy kept without STOP", 32'(v[0]), 1);
    wr(2'd2, 12'({SL, 1'b1})); wr(2'd0, BASE | STA | XF); wait_xfer("R4");
    chk("R4", "repeated START seen by target", s_starts - st0, 2);
    wr(2'd1, 12'h080);
    for (int i = 0; i < 3; i++) begin
      exp_rd.push_back(rdv(rn)); rn++;
      wr(2'd0, BASE | XF | ((i == 2) ? (STO | NAK) : 12'h0));
      wait_xfer("R5");
      rd(2'd1, v); chk("R5", "rx-full after read byte", 32'(v[7:4]), 32'h4);
      rd(2'd2, v); chk("R5", "received byte", 32'(v), 32'(exp_rd.pop_front()));
      wr(2'd1, 12'h040);
    end
    wait_idle("R5");
    chk("R5", "target released SDA after NACK", {scl_oe, sda_oe, s_oe}, 0);

    // R6 target does not acknowledge
    wr(2'd2, 12'({7'h22, 1'b0})); wr(2'd0, BASE | STA | XF); wait_xfer("R6");
    rd(2'd1, v);
    chk("R6", "bus-error flag only", 32'(v[7:4]), 32'h2);
    chk("R6", "busy clear after NACK", 32'(v[0]), 0);
    chk("R6", "lines released after NACK", {scl_oe, sda_oe}, 0);

    // R8 writing zero leaves the flag
    wr(2'd1, 12'h000); rd(2'd1, v); chk("R8", "flag kept on zero write", 32'(v[7:4]), 32'h2);

    // R9 interrupt masking
    @(negedge clk); chk("R9", "irq with enables off", 32'(irq), 0);
    wr(2'd0, BASE | 12'h400); @(negedge clk); chk("R9", "irq bus-error enabled", 32'(irq), 1);
    wr(2'd0, BASE | 12'h100); @(negedge clk); chk("R9", "irq other enable only", 32'(irq), 0);
    wr(2'd1, 12'h020); wr(2'd0, BASE | 12'h400); @(negedge clk);
    chk("R9", "irq after flag cleared", 32'(irq), 0);
    wr(2'd0, BASE);

    // R7 arbitration loss
    jam = 1'b1;
    wr(2'd2, 12'hB4); wr(2'd0, BASE | STA | XF); wait_xfer("R7");
    rd(2'd1, v);
    chk("R7", "arbitration flag only", 32'(v[7:4]), 32'h1);
    chk("R7", "lines released", {scl_oe, sda_oe}, 0);
    jam = 1'b0;
    wr(2'd1, 12'h010);
    repeat (4) @(posedge clk);

    // R10 unit disabled ignores transfer-byte
    wr(2'd0, 12'h002 | STA | XF);
    rd(2'd0, v); chk("R10", "transfer-byte dropped when disabled", 32'(v[6]), 0);
    repeat (40) @(posedge clk);
    rd(2'd1, v); chk("R10", "status untouched when disabled", 32'(v), 0);
    chk("R10", "lines idle when disabled", {scl_oe, sda_oe}, 0);

    // R10 unit reset mid-byte
    wr(2'd0, BASE); wr(2'd2, 12'hB4); wr(2'd0, BASE | STA | XF);
    repeat (40) @(posedge clk);
    wr(2'd0, URST); @(negedge clk);
    chk("R10", "lines released by unit reset", {scl_oe, sda_oe}, 0);
    wr(2'd1, 12'h0F0); wr(2'd0, 12'h000);
    rd(2'd1, v); chk("R10", "status after reset sequence", 32'(v), 0);
    rd(2'd0, v); chk("R10", "control after reset sequence", 32'(v), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule